// File: doc/BRIEF.md
# USB Device Endpoint Control Register

This block holds the control state of one endpoint of a high-speed USB device controller. Software writes it through a 32-bit register port with byte-lane enables. The controller's transfer engine updates it through single-cycle event inputs. The stored state covers the endpoint enable, a pending disable request, the NAK state, one bit that is the data-toggle PID or the (micro)frame parity, and a transmit FIFO number. Each of these is also driven out on its own port.

Four of the write bits are command strobes that are never stored. Two of them set or clear NAK. The other two force the toggle bit high or low, and their meaning depends on the endpoint type: for bulk and interrupt endpoints they pick DATA1 or DATA0, for isochronous endpoints they pick odd or even parity, and for control endpoints they do nothing.

Software asks for a disable by writing the disable bit. The transfer engine answers with a done event. At that point the register drops both the disable and the enable bits, and one cycle later it sends a one-cycle endpoint-disabled pulse to the interrupt logic.

Top module: `ep_ctrl_reg`

## Requirements
- R1: After reset, rd_data, enable, dis_pend, nak, pid_odd, txfifo_num and dis_irq are all 0.
- R2: A write with lane 3 enabled and bit 31 at 1 sets enable. Writing 0 to bit 31 leaves enable unchanged.
- R3: A write of 1 to bit 30 (lane 3) sets dis_pend only if enable was already 1 before that write. Otherwise the write is ignored: dis_pend stays 0 and dis_irq stays 0.
- R4: When evt_dis_done arrives while dis_pend is 1, the next clock edge clears both dis_pend and enable. A software set of enable or disable in that same cycle is dropped. dis_irq is 1 for exactly one cycle, starting one cycle after the clear. evt_dis_done while dis_pend is 0 has no effect.
- R5: The endpoint type is encoded as ep_kind 0=control, 1=isochronous, 2=bulk, 3=interrupt. For bulk and interrupt endpoints, writing 1 to bit 29 makes pid_odd 1 (DATA1) and writing 1 to bit 28 makes it 0 (DATA0). If both are written together, bit 28 wins.
- R6: For isochronous endpoints, bit 29 makes pid_odd 1 (odd frame) and bit 28 makes it 0 (even frame). If both are written together, bit 28 wins.
- R7: For control endpoints, bits 29 and 28 leave pid_odd unchanged.
- R8: Writing 1 to bit 27 sets nak. Writing 1 to bit 26 clears nak. If both are written together, nak ends at 1.
- R9: For OUT endpoints (ep_is_in=0), evt_setup or evt_xfer_done sets nak at the next edge, even if a clear-NAK write arrives in the same cycle. For IN endpoints these events leave nak unchanged.
- R10: The FIFO number is held in bits 25:22. On an IN endpoint with a periodic type (ep_kind 1 or 3), written bits are stored as given. On any other endpoint, written bits are stored as 0.
- R11: rd_data shows enable at bit 31, dis_pend at bit 30, the FIFO number at bits 25:22, nak at bit 17 and pid_odd at bit 16. All other bits read 0, including the strobe bits 29:26.
- R12: A write changes only the bits whose byte lane is enabled. FIFO bits 25:24 belong to lane 3 and bits 23:22 belong to lane 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| ep_kind | input | 2 | Endpoint type (0 control, 1 isochronous, 2 bulk, 3 interrupt) |
| ep_is_in | input | 1 | 1 for an IN endpoint |
| evt_setup | input | 1 | Core event: SETUP packet received |
| evt_xfer_done | input | 1 | Core event: transfer complete |
| evt_dis_done | input | 1 | Core event: endpoint has stopped |
| enable | output | 1 | Endpoint enable |
| dis_pend | output | 1 | Disable request pending |
| nak | output | 1 | Endpoint NAK state |
| pid_odd | output | 1 | DATA1 / odd-frame toggle |
| txfifo_num | output | 4 | Transmit FIFO number |
| dis_irq | output | 1 | Endpoint-disabled interrupt pulse |

## Verification
Two things can land in the same cycle. A software clear-NAK write can coincide with a SETUP or transfer-complete event. A disable-done event can coincide with a set-NAK write or an enable write. The bench drives each such pair on the same falling edge, for both endpoint directions and both event kinds. After the next rising edge it checks that nak is set for OUT endpoints and cleared for IN endpoints. It also checks that the disable handshake finishes with enable low and a single delayed pulse.

// File: rtl/ep_ctrl_pkg.sv
package ep_ctrl_pkg;

    typedef enum logic [1:0] {
        KIND_CTRL = 2'd0,
        KIND_ISOC = 2'd1,
        KIND_BULK = 2'd2,
        KIND_INTR = 2'd3
    } ep_kind_e;

    // bit positions that software and the transfer engine both depend on
    localparam int BIT_ENA      = 31;
    localparam int BIT_DIS      = 30;
    localparam int BIT_TGL_HI   = 29;
    localparam int BIT_TGL_LO   = 28;
    localparam int BIT_NAK_ON   = 27;
    localparam int BIT_NAK_OFF  = 26;
    localparam int BIT_FIFO_LSB = 22;
    localparam int BIT_NAK_STAT = 17;
    localparam int BIT_TGL_STAT = 16;

    typedef struct packed {
        logic ena_set;
        logic dis_req;
        logic tgl_hi;
        logic tgl_lo;
        logic nak_on;
        logic nak_off;
    } sw_cmd_t;

endpackage

// File: rtl/ep_ctrl_wr_decode.sv
module ep_ctrl_wr_decode
    import ep_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FIFO_W = 4
) (
    input  logic                  wr_en,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  fifo_ok,
    input  logic [FIFO_W-1:0]     fifo_q,
    output sw_cmd_t               cmd,
    output logic [FIFO_W-1:0]     fifo_d
);
    localparam int LANE_CMD = BIT_ENA / 8;

    logic cmd_lane;
    logic unused_wr;

    assign cmd_lane  = wr_en & wr_be[LANE_CMD];
    assign unused_wr = ^{wr_data, wr_be};

    always_comb begin
        cmd.ena_set = cmd_lane & wr_data[BIT_ENA];
        cmd.dis_req = cmd_lane & wr_data[BIT_DIS];
        cmd.tgl_hi  = cmd_lane & wr_data[BIT_TGL_HI];
        cmd.tgl_lo  = cmd_lane & wr_data[BIT_TGL_LO];
        cmd.nak_on  = cmd_lane & wr_data[BIT_NAK_ON];
        cmd.nak_off = cmd_lane & wr_data[BIT_NAK_OFF];
    end

    // each FIFO-number bit follows its own byte lane
    for (genvar i = 0; i < FIFO_W; i++) begin : g_fifo_bit
        localparam int POS = BIT_FIFO_LSB + i;
        assign fifo_d[i] = (wr_en && wr_be[POS/8]) ? (wr_data[POS] & fifo_ok)
                                                    : fifo_q[i];
    end

endmodule

// File: rtl/ep_ctrl_flow.sv
module ep_ctrl_flow
    import ep_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sw_cmd_t    cmd,
    input  logic [1:0] ep_kind,
    input  logic       ep_is_in,
    input  logic       evt_setup,
    input  logic       evt_xfer_done,
    output logic       nak,
    output logic       pid_odd
);
    typedef struct packed {
        logic nak;
        logic odd;
    } flow_t;

    flow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.nak_off) st_d.nak = 1'b0;
        if (cmd.nak_on)  st_d.nak = 1'b1;
        if (!ep_is_in && (evt_setup || evt_xfer_done)) st_d.nak = 1'b1;
        case (ep_kind_e'(ep_kind))
            KIND_ISOC, KIND_BULK, KIND_INTR: begin
                if (cmd.tgl_hi) st_d.odd = 1'b1;
                if (cmd.tgl_lo) st_d.odd = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nak     = st_q.nak;
    assign pid_odd = st_q.odd;

endmodule

// File: rtl/ep_ctrl_dis_hs.sv
module ep_ctrl_dis_hs
    import ep_ctrl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_cmd_t cmd,
    input  logic    evt_dis_done,
    output logic    enable,
    output logic    dis_pend,
    output logic    dis_irq
);
    typedef struct packed {
        logic ena;
        logic dis;
        logic ack;
        logic irq;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d     = hs_q;
        hs_d.irq = hs_q.ack;
        hs_d.ack = 1'b0;
        if (hs_q.dis && evt_dis_done) begin
            hs_d.ena = 1'b0;
            hs_d.dis = 1'b0;
            hs_d.ack = 1'b1;
        end else begin
            if (cmd.ena_set)              hs_d.ena = 1'b1;
            if (cmd.dis_req && hs_q.ena)  hs_d.dis = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign enable   = hs_q.ena;
    assign dis_pend = hs_q.dis;
    assign dis_irq  = hs_q.irq;

endmodule

// File: rtl/ep_ctrl_reg.sv
module ep_ctrl_reg
    import ep_ctrl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FIFO_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [1:0]          ep_kind,
    input  logic                ep_is_in,
    input  logic                evt_setup,
    input  logic                evt_xfer_done,
    input  logic                evt_dis_done,
    output logic                enable,
    output logic                dis_pend,
    output logic                nak,
    output logic                pid_odd,
    output logic [FIFO_W-1:0]   txfifo_num,
    output logic                dis_irq
);
    sw_cmd_t           cmd;
    logic              fifo_ok;
    logic [FIFO_W-1:0] fifo_d, fifo_q;

    assign fifo_ok = ep_is_in &&
                     (ep_kind_e'(ep_kind) == KIND_ISOC || ep_kind_e'(ep_kind) == KIND_INTR);

    ep_ctrl_wr_decode #(.DATA_W(DATA_W), .FIFO_W(FIFO_W)) u_dec (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .fifo_ok (fifo_ok),
        .fifo_q  (fifo_q),
        .cmd     (cmd),
        .fifo_d  (fifo_d)
    );

    ep_ctrl_flow u_flow (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd           (cmd),
        .ep_kind       (ep_kind),
        .ep_is_in      (ep_is_in),
        .evt_setup     (evt_setup),
        .evt_xfer_done (evt_xfer_done),
        .nak           (nak),
        .pid_odd       (pid_odd)
    );

    ep_ctrl_dis_hs u_hs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .evt_dis_done (evt_dis_done),
        .enable       (enable),
        .dis_pend     (dis_pend),
        .dis_irq      (dis_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    assign txfifo_num = fifo_q;

    always_comb begin
        rd_data                            = '0;
        rd_data[BIT_ENA]                   = enable;
        rd_data[BIT_DIS]                   = dis_pend;
        rd_data[BIT_FIFO_LSB +: FIFO_W]    = fifo_q;
        rd_data[BIT_NAK_STAT]              = nak;
        rd_data[BIT_TGL_STAT]              = pid_odd;
    end

endmodule

// File: rtl/ep_ctrl_reg_chk.sv
module ep_ctrl_reg_chk #(
    parameter int DATA_W = 32,
    parameter int FIFO_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [DATA_W/8-1:0] wr_be,
    input logic [DATA_W-1:0]   wr_data,
    input logic [1:0]          ep_kind,
    input logic                ep_is_in,
    input logic                evt_setup,
    input logic                evt_xfer_done,
    input logic                enable,
    input logic                dis_pend,
    input logic                nak,
    input logic                pid_odd,
    input logic [FIFO_W-1:0]   txfifo_num,
    input logic                dis_irq
);
    logic unused_chk;
    assign unused_chk = ^{wr_data, wr_be};

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dis_irq |=> !dis_irq);

    assert_irq_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dis_irq |-> (!enable && !dis_pend && $past(!dis_pend)));

    assert_dis_needs_ena_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dis_pend |-> enable);

    assert_dis_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dis_pend) |-> $past(enable));

    assert_out_evt_nak_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep_is_in && (evt_setup || evt_xfer_done)) |=> nak);

    assert_nak_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[3] && wr_data[27]) |=> nak);

    assert_fifo_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[3] && wr_be[2] && !(ep_is_in && ep_kind[0])) |=> (txfifo_num == '0));

    assert_ctrl_tgl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_kind == 2'd0) |=> $stable(pid_odd));

endmodule

bind ep_ctrl_reg ep_ctrl_reg_chk #(.DATA_W(DATA_W), .FIFO_W(FIFO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_be         (wr_be),
    .wr_data       (wr_data),
    .ep_kind       (ep_kind),
    .ep_is_in      (ep_is_in),
    .evt_setup     (evt_setup),
    .evt_xfer_done (evt_xfer_done),
    .enable        (enable),
    .dis_pend      (dis_pend),
    .nak           (nak),
    .pid_odd       (pid_odd),
    .txfifo_num    (txfifo_num),
    .dis_irq       (dis_irq)
);

// File: tb/tb_ep_ctrl_reg.sv
`timescale 1ns/1ps
module tb_ep_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  ep_kind = '0;
    logic        ep_is_in = 1'b0;
    logic        evt_setup = 1'b0, evt_xfer_done = 1'b0, evt_dis_done = 1'b0;
    logic        enable, dis_pend, nak, pid_odd, dis_irq;
    logic [3:0]  txfifo_num;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ep_ctrl_reg dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [3:0] be, input logic [31:0] d,
                         input logic su, input logic xd, input logic dd);
        @(negedge clk);
        wr_en = en; wr_be = be; wr_data = d;
        evt_setup = su; evt_xfer_done = xd; evt_dis_done = dd;
        @(negedge clk);
        wr_en = 0; wr_be = '0; wr_data = '0;
        evt_setup = 0; evt_xfer_done = 0; evt_dis_done = 0;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        drive(1'b1, be, d, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic m_nak, m_odd;
        logic [3:0] m_fifo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 outputs", {enable, dis_pend, nak, pid_odd, dis_irq, txfifo_num}, 0);

        // lane 3 masked: enable bit must not land
        wr(4'b0111, 32'h8000_0000);
        chk("R12 enable lane off", enable, 0);

        // disable with enable low is ignored
        wr(4'hF, 32'h4000_0000);
        chk("R3 dis ignored", dis_pend, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 no irq", dis_irq, 0);
        end

        wr(4'hF, 32'h0);
        chk("R2 zero keeps", enable, 0);
        wr(4'hF, 32'h8000_0000);
        chk("R2 enable set", enable, 1);
        wr(4'hF, 32'h0);
        chk("R2 zero no clear", enable, 1);

        // disable handshake
        wr(4'hF, 32'h4000_0000);
        chk("R3 dis accepted", dis_pend, 1);
        drive(1'b1, 4'hF, 32'h8800_0000, 1'b0, 1'b0, 1'b1); // done + enable + set-NAK
        chk("R4 cleared", {enable, dis_pend}, 2'b00);
        chk("R4 irq not yet", dis_irq, 0);
        chk("R8 nak with done", nak, 1);
        @(negedge clk);
        chk("R4 irq pulse", dis_irq, 1);
        @(negedge clk);
        chk("R4 irq single", dis_irq, 0);

        // done while nothing pending
        wr(4'hF, 32'h8000_0000);
        drive(1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 1'b1);
        chk("R4 stray done", enable, 1);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R4 stray no irq", dis_irq, 0);
        end

        // strobe sweep over type, direction, 16 strobe combos
        m_nak = nak; m_odd = pid_odd;
        for (int k = 0; k < 4; k++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int c = 0; c < 16; c++) begin
                    logic [3:0] s;
                    s = 4'(c);
                    ep_kind = 2'(k); ep_is_in = dir[0];
                    wr(4'b1000, {2'b10, s, 26'h0});
                    m_nak = s[1] | (m_nak & ~s[0]);
                    if (k != 0) m_odd = ~s[2] & (s[3] | m_odd);
                    chk("R8 nak strobe", nak, m_nak);
                    if (k == 0)      chk("R7 ctrl toggle", pid_odd, m_odd);
                    else if (k == 1) chk("R6 iso parity", pid_odd, m_odd);
                    else             chk("R5 data pid", pid_odd, m_odd);
                    chk("R11 strobes read 0", rd_data[29:26], 0);
                end
            end
        end

        // collision: clear-NAK write with core events
        for (int dir = 0; dir < 2; dir++) begin
            for (int ev = 0; ev < 2; ev++) begin
                ep_is_in = dir[0];
                wr(4'b1000, 32'h0400_0000);
                drive(1'b1, 4'b1000, 32'h0400_0000, ev == 0, ev == 1, 1'b0);
                chk("R9 event vs clear", nak, dir == 0 ? 1 : 0);
            end
        end

        // FIFO number sweep
        for (int k = 0; k < 4; k++) begin
            for (int dir = 0; dir < 2; dir++) begin
                ep_kind = 2'(k); ep_is_in = dir[0];
                wr(4'b1100, 32'hA << 22);
                m_fifo = (dir == 1 && (k == 1 || k == 3)) ? 4'hA : 4'h0;
                chk("R10 fifo", txfifo_num, m_fifo);
                chk("R11 fifo readback", rd_data[25:22], m_fifo);
            end
        end

        ep_kind = 2'd1; ep_is_in = 1'b1;
        wr(4'b1100, 32'hF << 22);
        chk("R12 fifo both lanes", txfifo_num, 4'hF);
        wr(4'b1000, 32'h0);
        chk("R12 fifo lane3", txfifo_num, 4'h3);
        wr(4'b0100, 32'h0);
        chk("R12 fifo lane2", txfifo_num, 4'h0);

        // full readback
        wr(4'b1100, 32'hA8C0_0000); // enable, toggle hi, set-NAK, fifo 3
        chk("R11 word", rd_data, 32'h80C3_0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule